// File: doc/BRIEF.md
# Radio Control-Port Command Snooper

This block listens, without ever driving anything, to the control port of a sub-GHz radio transceiver. An upstream SPI deserializer hands it one strobe per transferred byte, with the byte the host sent and the byte the radio answered. Every radio command is two bytes long. The block therefore pairs the bytes, classifies the command from its first host byte, and emits a one-cycle `cmd_done` pulse. Its registered outputs hold the command kind, a decoded field value and a set of changed-field flags until the next command.

To tell what changed, the block keeps its own copy of each radio configuration register. Each copy starts from the radio's power-up value and is restored by a software-reset command. Power commands give the bits that were switched on and the bits that were switched off, after applying the rule that some enables force others. Status reads give the 11-bit flag word, the 5-bit AFC offset, and a mode bit that says whether the two shared flags describe the receive side or the transmit side.

Top module: `radio_cmd_snoop`

## Requirements
- R1: A command completes on the second accepted `byte_vld` after reset, after `frame_rst`, or after the previous command. `cmd_done` is high for exactly the one cycle after the clock edge that sampled that second byte. `cmd_word` is {first host byte, second host byte}. All decode outputs keep their values until the next `cmd_done`.
- R2: When `frame_rst` is high at a clock edge, any half-received command is discarded and the byte strobed in that cycle is ignored. The next accepted byte starts a new command.
- R3: `cmd_kind` is decided from the first host byte in this priority order: 0x80→1 config, 0x82→2 power, (b&0xF0)=0xA0→3 frequency, 0xC6→4 data rate, (b&0xF8)=0x90→5 receiver control, 0xC2→6 data filter, 0xCA→7 FIFO/reset, 0xCE→8 sync pattern, 0xB0→9 FIFO read, 0xC4→10 AFC, (b&0xFE)=0x98→11 transceiver control, 0xCC→12 PLL, 0xB8→13 transmit register, 0xFE→14 software reset, (b&0xE0)=0xE0→15 wake-up timer, 0xC8→16 low duty cycle, 0xC0→17 battery/clock, 0x00→18 status read. Any other byte gives 0 (unknown). 0xFE is therefore software reset, not wake-up.
- R4: After reset every output is 0. The shadow copies hold config 0x08, power 0x08, frequency 0x680, data rate 0x23, FIFO/reset 0x80, AFC 0xF7, transceiver 0x00, PLL 0x77 and last status 0x0000.
- R5: Frequency: `field_value` is {4'b0, byte0[3:0], byte1}. `chg_flags[0]` is set when that 12-bit value differs from the shadow, and the shadow is then updated.
- R6: Power: the effective byte is byte1, ORed with 0x58 when bit 7 is set and with 0x18 when bit 5 is set. `field_value` is {8'h00, effective}. `pwr_on` holds the bits that are 1 now and were 0 in the shadow, `pwr_off` holds the bits that are 0 now and were 1. The effective byte is then stored. For every other kind both are 0.
- R7: Config flags: [0] bits 7:6, [1] band bits 5:4, [2] capacitance bits 3:0. FIFO/reset flags: [0] trigger level 7:4, [1] sync length bit 3, [2] fill mode 2:1, [3] reset mode bit 0. Each flag is set when its field differs from the shadow. Both kinds store byte1 in their shadow.
- R8: Status read: `status_flags` = {reply0, reply1[7:5]}, `afc_offset` = reply1[4:0], `field_value` = the 16-bit reply, and `chg_flags[0]` is set when the offset differs from the last status. The reply is saved as the last status. `status_flags`, `afc_offset` and `rx_mode` change only on status reads.
- R9: On a status read, `rx_mode` takes bit 7 of the power shadow as it stood before that command. 1 means the shared flags report RX data and overflow, 0 means TX ready and underrun.
- R10: Sync pattern: `field_value` is {0x2D, byte1} when bit 3 of the FIFO/reset shadow is set, otherwise {0x00, byte1}.
- R11: A software-reset command restores every shadow copy to its R4 value.
- R12: Data rate flag [0] is set on any change of the whole byte. AFC flags: [0] bits 7:6, [1] bits 5:4, [2] bits 3:0. Transceiver flags: [0] bits 7:4, [1] bits 2:0. PLL flags: [0] bits 3:2, [1] bit 0. `field_value` is the reply's second byte for FIFO read and {3'b0, cmd[12:0]} for wake-up. For every other kind not named in R5 to R10 it is {8'h00, byte1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One transferred byte pair is present |
| mosi_byte | input | 8 | Byte sent by the host |
| miso_byte | input | 8 | Byte returned by the radio |
| frame_rst | input | 1 | Discard any partly received command |
| cmd_done | output | 1 | One-cycle pulse: decode outputs refreshed |
| cmd_kind | output | 5 | Command kind code (R3) |
| cmd_word | output | 16 | Raw two-byte host command |
| field_value | output | 16 | Decoded value for the command kind |
| chg_flags | output | 4 | Per-field changed flags |
| pwr_on | output | 8 | Power bits switched on |
| pwr_off | output | 8 | Power bits switched off |
| status_flags | output | 11 | Flag word from the last status read |
| afc_offset | output | 5 | AFC offset from the last status read |
| rx_mode | output | 1 | Shared status flags describe the receive side |

## Verification
The assertions assume that reset is held low from the first clock edge. They also assume that `byte_vld` is a level sampled at each edge, so two strobes in back-to-back cycles are two bytes. Given those inputs, two `cmd_done` pulses can never be adjacent and outputs may move only on a pulse. The stimulus drives inputs on the falling edge only, releases reset before the first byte, and never raises `frame_rst` while a command is expected to complete.

// File: rtl/radio_snoop_pkg.sv
// Package: shared command kind codes and power-up shadow values for the
// radio control-port snooper. Assumes 8-bit SPI transfers.
package radio_snoop_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int KIND_W   = 5;
    localparam int FREQ_W   = 12;
    localparam int STAT_W   = 11;
    localparam int AFC_W    = 5;
    localparam int CHG_W    = 4;

    typedef enum logic [KIND_W-1:0] {
        K_UNKNOWN = 5'd0,
        K_CONFIG  = 5'd1,
        K_POWER   = 5'd2,
        K_FREQ    = 5'd3,
        K_RATE    = 5'd4,
        K_RXCTL   = 5'd5,
        K_FILTER  = 5'd6,
        K_FIFO    = 5'd7,
        K_SYNC    = 5'd8,
        K_FIFORD  = 5'd9,
        K_AFC     = 5'd10,
        K_TXCTL   = 5'd11,
        K_PLL     = 5'd12,
        K_TXREG   = 5'd13,
        K_SWRESET = 5'd14,
        K_WAKEUP  = 5'd15,
        K_LOWDUTY = 5'd16,
        K_BATCLK  = 5'd17,
        K_STATUS  = 5'd18
    } cmd_kind_e;

    localparam logic [BYTE_W-1:0] POR_CONFIG = 8'h08;
    localparam logic [BYTE_W-1:0] POR_POWER  = 8'h08;
    localparam logic [FREQ_W-1:0] POR_FREQ   = 12'h680;
    localparam logic [BYTE_W-1:0] POR_RATE   = 8'h23;
    localparam logic [BYTE_W-1:0] POR_FIFO   = 8'h80;
    localparam logic [BYTE_W-1:0] POR_AFC    = 8'hF7;
    localparam logic [BYTE_W-1:0] POR_TXCTL  = 8'h00;
    localparam logic [BYTE_W-1:0] POR_PLL    = 8'h77;
    localparam logic [WORD_W-1:0] POR_STATUS = 16'h0000;

    localparam logic [BYTE_W-1:0] SYNC_FIXED_HI = 8'h2D;
    localparam logic [BYTE_W-1:0] RX_IMPLY     = 8'h58;
    localparam logic [BYTE_W-1:0] TX_IMPLY     = 8'h18;

endpackage

// File: rtl/snoop_byte_pair.sv
// Byte pairer: collects two consecutive byte strobes into one command.
// Assumes byte_vld is a per-cycle level; frame_rst wins over byte_vld.
module snoop_byte_pair
    import radio_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              frame_rst,
    input  logic [BYTE_W-1:0] mosi_byte,
    input  logic [BYTE_W-1:0] miso_byte,
    output logic              pair_done,
    output logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] ret_word
);

    logic              have_first;
    logic [BYTE_W-1:0] mosi_hold;
    logic [BYTE_W-1:0] miso_hold;

    // Track whether the first byte of a command has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_rst) begin
            have_first <= 1'b0;
        end else if (byte_vld) begin
            have_first <= !have_first;
        end
    end

    // Hold the first byte pair until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mosi_hold <= '0;
            miso_hold <= '0;
        end else if (byte_vld && !frame_rst && !have_first) begin
            mosi_hold <= mosi_byte;
            miso_hold <= miso_byte;
        end
    end

    // Present the complete command in the cycle its second byte is strobed.
    always_comb begin
        pair_done = byte_vld && have_first && !frame_rst;
        cmd_word  = {mosi_hold, mosi_byte};
        ret_word  = {miso_hold, miso_byte};
    end

endmodule

// File: rtl/snoop_opcode_class.sv
// Opcode classifier: maps the first host byte to a command kind through a
// priority-ordered list of exact and masked matches. Purely combinational.
module snoop_opcode_class
    import radio_snoop_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output cmd_kind_e         kind
);

    // Walk the rules in priority order; the first match wins.
    always_comb begin
        if      (opcode == 8'h80)             kind = K_CONFIG;
        else if (opcode == 8'h82)             kind = K_POWER;
        else if ((opcode & 8'hF0) == 8'hA0)   kind = K_FREQ;
        else if (opcode == 8'hC6)             kind = K_RATE;
        else if ((opcode & 8'hF8) == 8'h90)   kind = K_RXCTL;
        else if (opcode == 8'hC2)             kind = K_FILTER;
        else if (opcode == 8'hCA)             kind = K_FIFO;
        else if (opcode == 8'hCE)             kind = K_SYNC;
        else if (opcode == 8'hB0)             kind = K_FIFORD;
        else if (opcode == 8'hC4)             kind = K_AFC;
        else if ((opcode & 8'hFE) == 8'h98)   kind = K_TXCTL;
        else if (opcode == 8'hCC)             kind = K_PLL;
        else if (opcode == 8'hB8)             kind = K_TXREG;
        else if (opcode == 8'hFE)             kind = K_SWRESET;
        else if ((opcode & 8'hE0) == 8'hE0)   kind = K_WAKEUP;
        else if (opcode == 8'hC8)             kind = K_LOWDUTY;
        else if (opcode == 8'hC0)             kind = K_BATCLK;
        else if (opcode == 8'h00)             kind = K_STATUS;
        else                                  kind = K_UNKNOWN;
    end

endmodule

// File: rtl/snoop_decode_core.sv
// Decode core: keeps shadow copies of the radio registers, compares each
// completed command against them and registers the decode outputs.
// Assumes pair_done never occurs in two consecutive cycles.
module snoop_decode_core
    import radio_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_done,
    input  logic [WORD_W-1:0] cmd_in,
    input  logic [WORD_W-1:0] ret_in,
    input  cmd_kind_e         kind_in,
    output logic              cmd_done,
    output logic [KIND_W-1:0] kind_out,
    output logic [WORD_W-1:0] cmd_out,
    output logic [WORD_W-1:0] field_out,
    output logic [CHG_W-1:0]  chg_out,
    output logic [BYTE_W-1:0] on_out,
    output logic [BYTE_W-1:0] off_out,
    output logic [STAT_W-1:0] stat_out,
    output logic [AFC_W-1:0]  afc_out,
    output logic              rxm_out
);

    localparam int WAKE_W = 13;

    logic [BYTE_W-1:0] cfg_q, pwr_q, rate_q, fifo_q, afc_q, txc_q, pll_q;
    logic [FREQ_W-1:0] freq_q;
    logic [WORD_W-1:0] stat_q;

    logic [BYTE_W-1:0] b0, b1;
    logic [FREQ_W-1:0] freq_new;
    logic [BYTE_W-1:0] pwr_eff;
    logic [BYTE_W-1:0] pwr_rise, pwr_fall;
    logic [WORD_W-1:0] field_d;
    logic [CHG_W-1:0]  chg_d;
    logic [BYTE_W-1:0] on_d, off_d;
    logic              sw_reset;

    // Split the command and form the derived frequency and power values.
    always_comb begin
        b0       = cmd_in[WORD_W-1:BYTE_W];
        b1       = cmd_in[BYTE_W-1:0];
        freq_new = {b0[3:0], b1};
        pwr_eff  = b1 | (b1[7] ? RX_IMPLY : '0) | (b1[5] ? TX_IMPLY : '0);
        sw_reset = pair_done && (kind_in == K_SWRESET);
    end

    // Per-bit power transitions against the shadow copy.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_pwr_edge
        assign pwr_rise[i] =  pwr_eff[i] && !pwr_q[i];
        assign pwr_fall[i] = !pwr_eff[i] &&  pwr_q[i];
    end

    // Select the decoded value and changed flags for the command kind.
    always_comb begin
        field_d = {8'h00, b1};
        chg_d   = '0;
        on_d    = '0;
        off_d   = '0;
        case (kind_in)
            K_CONFIG: chg_d = {1'b0, b1[3:0] != cfg_q[3:0],
                               b1[5:4] != cfg_q[5:4], b1[7:6] != cfg_q[7:6]};
            K_POWER: begin
                field_d = {8'h00, pwr_eff};
                on_d    = pwr_rise;
                off_d   = pwr_fall;
            end
            K_FREQ: begin
                field_d = {4'h0, freq_new};
                chg_d   = {3'b000, freq_new != freq_q};
            end
            K_RATE:   chg_d = {3'b000, b1 != rate_q};
            K_FIFO:   chg_d = {b1[0] != fifo_q[0], b1[2:1] != fifo_q[2:1],
                               b1[3] != fifo_q[3], b1[7:4] != fifo_q[7:4]};
            K_SYNC:   field_d = fifo_q[3] ? {SYNC_FIXED_HI, b1} : {8'h00, b1};
            K_FIFORD: field_d = {8'h00, ret_in[BYTE_W-1:0]};
            K_AFC:    chg_d = {1'b0, b1[3:0] != afc_q[3:0],
                               b1[5:4] != afc_q[5:4], b1[7:6] != afc_q[7:6]};
            K_TXCTL:  chg_d = {2'b00, b1[2:0] != txc_q[2:0], b1[7:4] != txc_q[7:4]};
            K_PLL:    chg_d = {2'b00, b1[0] != pll_q[0], b1[3:2] != pll_q[3:2]};
            K_WAKEUP: field_d = {3'b000, cmd_in[WAKE_W-1:0]};
            K_STATUS: begin
                field_d = ret_in;
                chg_d   = {3'b000, ret_in[AFC_W-1:0] != stat_q[AFC_W-1:0]};
            end
            default: ;
        endcase
    end

    // Maintain the shadow registers; reset or a software reset restores them.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            cfg_q  <= POR_CONFIG;
            pwr_q  <= POR_POWER;
            freq_q <= POR_FREQ;
            rate_q <= POR_RATE;
            fifo_q <= POR_FIFO;
            afc_q  <= POR_AFC;
            txc_q  <= POR_TXCTL;
            pll_q  <= POR_PLL;
            stat_q <= POR_STATUS;
        end else if (pair_done) begin
            case (kind_in)
                K_CONFIG: cfg_q  <= b1;
                K_POWER:  pwr_q  <= pwr_eff;
                K_FREQ:   freq_q <= freq_new;
                K_RATE:   rate_q <= b1;
                K_FIFO:   fifo_q <= b1;
                K_AFC:    afc_q  <= b1;
                K_TXCTL:  txc_q  <= b1;
                K_PLL:    pll_q  <= b1;
                K_STATUS: stat_q <= ret_in;
                default: ;
            endcase
        end
    end

    // Register the decode outputs once per completed command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done  <= 1'b0;
            kind_out  <= '0;
            cmd_out   <= '0;
            field_out <= '0;
            chg_out   <= '0;
            on_out    <= '0;
            off_out   <= '0;
            stat_out  <= '0;
            afc_out   <= '0;
            rxm_out   <= 1'b0;
        end else begin
            cmd_done <= pair_done;
            if (pair_done) begin
                kind_out  <= kind_in;
                cmd_out   <= cmd_in;
                field_out <= field_d;
                chg_out   <= chg_d;
                on_out    <= on_d;
                off_out   <= off_d;
                if (kind_in == K_STATUS) begin
                    stat_out <= {ret_in[WORD_W-1:BYTE_W], ret_in[7:5]};
                    afc_out  <= ret_in[AFC_W-1:0];
                    rxm_out  <= pwr_q[7];
                end
            end
        end
    end

    // A completion pulse is never followed directly by another.
    assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // Outputs move only together with a completion pulse.
    assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> ($stable(field_out) && $stable(kind_out) && $stable(chg_out)));

    // 0xFE always decodes as software reset, never as wake-up.
    assert_fe_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_out[WORD_W-1:BYTE_W] == 8'hFE) |-> kind_out == K_SWRESET);

    // A bit cannot be switched on and off by the same command.
    assert_power_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ((on_out & off_out) == '0));

    // An enabled receiver forces the baseband, synthesizer and oscillator bits.
    assert_power_imply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && kind_out == K_POWER && field_out[7]) |->
        (field_out[6] && field_out[4] && field_out[3]));

    // Commands other than power report no power transitions.
    assert_power_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && kind_out != K_POWER) |-> (on_out == '0 && off_out == '0));

endmodule

// File: rtl/radio_cmd_snoop.sv
// Top: passive snooper of a radio transceiver control port. Pairs bytes into
// commands, classifies them and reports decoded fields against shadow state.
// Assumes an upstream deserializer delivers one byte pair per byte_vld.
module radio_cmd_snoop
    import radio_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        mosi_byte,
    input  logic [7:0]        miso_byte,
    input  logic              frame_rst,
    output logic              cmd_done,
    output logic [4:0]        cmd_kind,
    output logic [15:0]       cmd_word,
    output logic [15:0]       field_value,
    output logic [3:0]        chg_flags,
    output logic [7:0]        pwr_on,
    output logic [7:0]        pwr_off,
    output logic [10:0]       status_flags,
    output logic [4:0]        afc_offset,
    output logic              rx_mode
);

    logic              pair_done;
    logic [WORD_W-1:0] pair_cmd;
    logic [WORD_W-1:0] pair_ret;
    cmd_kind_e         pair_kind;

    snoop_byte_pair i_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .frame_rst (frame_rst),
        .mosi_byte (mosi_byte),
        .miso_byte (miso_byte),
        .pair_done (pair_done),
        .cmd_word  (pair_cmd),
        .ret_word  (pair_ret)
    );

    snoop_opcode_class i_class (
        .opcode (pair_cmd[WORD_W-1:BYTE_W]),
        .kind   (pair_kind)
    );

    snoop_decode_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_done (pair_done),
        .cmd_in    (pair_cmd),
        .ret_in    (pair_ret),
        .kind_in   (pair_kind),
        .cmd_done  (cmd_done),
        .kind_out  (cmd_kind),
        .cmd_out   (cmd_word),
        .field_out (field_value),
        .chg_out   (chg_flags),
        .on_out    (pwr_on),
        .off_out   (pwr_off),
        .stat_out  (status_flags),
        .afc_out   (afc_offset),
        .rxm_out   (rx_mode)
    );

endmodule

// File: tb/test_radio_cmd_snoop.sv
module test_radio_cmd_snoop;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  mosi_byte = '0;
    logic [7:0]  miso_byte = '0;
    logic        frame_rst = 1'b0;
    logic        cmd_done;
    logic [4:0]  cmd_kind;
    logic [15:0] cmd_word;
    logic [15:0] field_value;
    logic [3:0]  chg_flags;
    logic [7:0]  pwr_on;
    logic [7:0]  pwr_off;
    logic [10:0] status_flags;
    logic [4:0]  afc_offset;
    logic        rx_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    radio_cmd_snoop i_radio_cmd_snoop (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
        .miso_byte(miso_byte), .frame_rst(frame_rst), .cmd_done(cmd_done),
        .cmd_kind(cmd_kind), .cmd_word(cmd_word), .field_value(field_value),
        .chg_flags(chg_flags), .pwr_on(pwr_on), .pwr_off(pwr_off),
        .status_flags(status_flags), .afc_offset(afc_offset), .rx_mode(rx_mode)
    );

    // Vector: host cmd, reply, kind, field, chg, pwr_on, pwr_off (hex digits 4/4/2/4/2/2/2).
    localparam int NVEC = 28;
    localparam logic [79:0] VEC [0:NVEC-1] = '{
        80'h80E7_0000_01_00E7_07_00_00,
        80'h80E7_0000_01_00E7_00_00_00,
        80'hA640_0000_03_0640_01_00_00,
        80'hA640_0000_03_0640_00_00_00,
        80'hC623_0000_04_0023_00_00_00,
        80'hC647_0000_04_0047_01_00_00,
        80'h94A0_0000_05_00A0_00_00_00,
        80'hC2AC_0000_06_00AC_00_00_00,
        80'hCA81_0000_07_0081_08_00_00,
        80'hCED4_0000_08_00D4_00_00_00,
        80'hCA8B_0000_07_008B_06_00_00,
        80'hCED4_0000_08_2DD4_00_00_00,
        80'hB000_005A_09_005A_00_00_00,
        80'hC483_0000_0A_0083_07_00_00,
        80'h9850_0000_0B_0050_01_00_00,
        80'h9A50_0000_00_0050_00_00_00,
        80'hCC77_0000_0C_0077_00_00_00,
        80'hCC72_0000_0C_0072_03_00_00,
        80'hB8AA_0000_0D_00AA_00_00_00,
        80'hE123_0000_0F_0123_00_00_00,
        80'hC80E_0000_10_000E_00_00_00,
        80'hC0E0_0000_11_00E0_00_00_00,
        80'hFE00_0000_0E_0000_00_00_00,
        80'h8008_0000_01_0008_00_00_00,
        80'h82A0_0000_02_00F8_00_F0_00,
        80'h8201_0000_02_0001_00_01_F8,
        80'h7F12_0000_00_0012_00_00_00,
        80'hFF00_0000_0F_1F00_00_00_00
    };

    function automatic string req_of(input logic [4:0] k);
        case (k)
            5'd1, 5'd7: return "R7";
            5'd2:       return "R6";
            5'd3:       return "R5";
            5'd8:       return "R10";
            5'd14:      return "R11";
            5'd18:      return "R8";
            default:    return "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive two bytes on falling edges; return at the falling edge after completion.
    task automatic send_cmd(input logic [15:0] host, input logic [15:0] reply);
        @(negedge clk);
        byte_vld = 1'b1; mosi_byte = host[15:8]; miso_byte = reply[15:8];
        @(negedge clk);
        mosi_byte = host[7:0]; miso_byte = reply[7:0];
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic expect_status(input string tag, input logic [10:0] flags,
                                 input logic [4:0] afc, input logic chg, input logic rxm);
        check(cmd_kind == 5'd18, "R3", {tag, " kind"}, 32'(cmd_kind), 32'd18);
        check(status_flags == flags, "R8", {tag, " flags"}, 32'(status_flags), 32'(flags));
        check(afc_offset == afc, "R8", {tag, " afc"}, 32'(afc_offset), 32'(afc));
        check(chg_flags[0] == chg, "R8", {tag, " afc chg"}, 32'(chg_flags[0]), 32'(chg));
        check(rx_mode == rxm, "R9", {tag, " rx_mode"}, 32'(rx_mode), 32'(rxm));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        check(cmd_done == 1'b0, "R4", "cmd_done", 32'(cmd_done), 0);
        check(cmd_kind == 5'd0, "R4", "cmd_kind", 32'(cmd_kind), 0);
        check(field_value == 16'h0, "R4", "field", 32'(field_value), 0);
        check(status_flags == 11'h0 && rx_mode == 1'b0, "R4", "status",
              32'(status_flags), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [79:0] v;
            v = VEC[i];
            send_cmd(v[79:64], v[63:48]);
            check(cmd_done == 1'b1, "R1", $sformatf("done v%0d", i), 32'(cmd_done), 1);
            check(cmd_word == v[79:64], "R1", $sformatf("word v%0d", i),
                  32'(cmd_word), 32'(v[79:64]));
            check(cmd_kind == v[44:40], "R3", $sformatf("kind v%0d", i),
                  32'(cmd_kind), 32'(v[44:40]));
            check(field_value == v[39:24], req_of(v[44:40]), $sformatf("field v%0d", i),
                  32'(field_value), 32'(v[39:24]));
            check(chg_flags == v[19:16], req_of(v[44:40]), $sformatf("chg v%0d", i),
                  32'(chg_flags), 32'(v[19:16]));
            check(pwr_on == v[15:8] && pwr_off == v[7:0], "R6", $sformatf("pwr v%0d", i),
                  32'({pwr_on, pwr_off}), 32'(v[15:0]));
            if (i == 0) begin
                @(negedge clk);
                // R1: one-cycle pulse, outputs held
                check(cmd_done == 1'b0, "R1", "pulse width", 32'(cmd_done), 0);
                check(field_value == 16'h00E7, "R1", "hold", 32'(field_value), 32'h00E7);
            end
        end

        // R8/R9: status read with power shadow 0x01 (receiver off)
        send_cmd(16'h0000, 16'hA53F);
        expect_status("st1", 11'h529, 5'h1F, 1'b1, 1'b0);
        check(field_value == 16'hA53F, "R8", "st1 field", 32'(field_value), 32'hA53F);
        send_cmd(16'h8280, 16'h0000);
        check(field_value == 16'h00D8 && pwr_on == 8'hD8 && pwr_off == 8'h01, "R6",
              "rx enable", 32'({field_value, pwr_on, pwr_off}), 32'h00D8_D801);
        check(status_flags == 11'h529, "R8", "status held", 32'(status_flags), 32'h529);
        send_cmd(16'h0000, 16'h8020);
        expect_status("st2", 11'h401, 5'h00, 1'b1, 1'b1);
        send_cmd(16'h0000, 16'h8020);
        expect_status("st3", 11'h401, 5'h00, 1'b0, 1'b1);

        // R2: half command discarded by frame_rst
        @(negedge clk);
        byte_vld = 1'b1; mosi_byte = 8'h80; miso_byte = 8'h00;
        @(negedge clk);
        byte_vld = 1'b0; frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        check(cmd_done == 1'b0, "R2", "no done", 32'(cmd_done), 0);
        send_cmd(16'hC699, 16'h0000);
        check(cmd_kind == 5'd4 && field_value == 16'h0099, "R2", "fresh cmd",
              32'({cmd_kind, field_value}), 32'({5'd4, 16'h0099}));

        // R11: software reset restores shadows
        send_cmd(16'hFE00, 16'h0000);
        check(cmd_kind == 5'd14, "R11", "swreset kind", 32'(cmd_kind), 14);
        send_cmd(16'hCE11, 16'h0000);
        check(field_value == 16'h0011, "R11", "fifo restored", 32'(field_value), 32'h0011);
        send_cmd(16'hA680, 16'h0000);
        check(chg_flags == 4'h0, "R11", "freq restored", 32'(chg_flags), 0);
        send_cmd(16'h0000, 16'h0000);
        expect_status("st4", 11'h000, 5'h00, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule